// File: doc/BRIEF.md
# Load-Store Target Address Generator with Alignment Check

This block computes the effective address of a memory or branch operation on a RISC machine with fixed 32-bit instructions. It holds a 32-entry, 64-bit integer register file in which entry 0 is hard-wired to zero. For each valid request it forms an address in one of three ways:

- the program counter plus a word-scaled signed displacement, for branches only;
- a register plus a signed 13-bit immediate;
- the sum of two registers.

It then returns the address one clock later.

For loads and stores the block also checks that the address is a multiple of the access size. It flags a misalignment fault if it is not. It raises a mode fault when a request uses an addressing form that the operation may not use. The surrounding pipeline writes results into the register file through a single write port, and it consumes the address and the two fault flags. Memory, translation and trap handling sit outside the block.

Top module: `lsu_addr_gen`

## Requirements
- R1: With `req_mode` = 0 (PC-relative), the address is `req_pc` plus the 30-bit signed `req_disp` shifted left by two, wrapping modulo 2^64.
- R2: With `req_mode` = 1 (register plus immediate), the address is register `req_rs1` plus the sign-extended 13-bit `req_imm`, wrapping modulo 2^64.
- R3: With `req_mode` = 2 (register plus register), the address is register `req_rs1` plus register `req_rs2`, wrapping modulo 2^64.
- R4: `out_mode_fault` is raised when `req_mode` = 0 and `req_is_branch` = 0, or when `req_mode` = 3 (reserved, address reported as 0). It is never raised by a branch using modes 0, 1 or 2, nor by a load or store using modes 1 or 2.
- R5: For a load or store (`req_is_branch` = 0) in mode 1 or 2, `out_misalign` is raised when the address is not a multiple of the access size. `req_size` encodes the size as 0 = byte, 1 = halfword (2 bytes), 2 = word (4 bytes) and 3 = doubleword (8 bytes).
- R6: A byte access (`req_size` = 0) never raises `out_misalign`.
- R7: Register 0 always reads as zero, and a write to index 0 has no effect.
- R8: The outputs of a request appear on the clock edge that follows it, with `out_valid` high. In a cycle after no valid request, `out_valid`, `out_misalign` and `out_mode_fault` are all low.
- R9: A register write becomes visible to a request made in any later cycle. Reset clears every register to zero.
- R10: Branch requests and mode 0 or mode 3 requests never raise `out_misalign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register file write enable |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 64 | Data to write |
| req_valid | input | 1 | Address request present |
| req_mode | input | 2 | 0 PC-relative, 1 register+immediate, 2 register+register, 3 reserved |
| req_is_branch | input | 1 | Request comes from a branch rather than a load or store |
| req_rs1 | input | 5 | First source register index |
| req_rs2 | input | 5 | Second source register index |
| req_imm | input | 13 | Signed immediate offset in bytes |
| req_disp | input | 30 | Signed displacement in words |
| req_pc | input | 64 | Program counter of the request |
| req_size | input | 2 | Access size code |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Target address |
| out_misalign | output | 1 | Misaligned access fault |
| out_mode_fault | output | 1 | Illegal addressing mode fault |

## Verification
The assertions assume that reset is held long enough to clear the register file, and that `req_valid` stays low while reset is active. They place no limit on field values, so any mode, size and index combination must be legal stimulus. The bench keeps requests and writes one cycle apart, and it drives all inputs only on the falling edge. It sweeps every mode, operation kind and size against a chosen set of registers, offsets and program counters. These sets include wrap-around at both ends of the address space and the extreme values of each signed field.

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int XLEN   = 64,
  parameter int NREGS  = 32,
  parameter int IMM_W  = 13,
  parameter int DISP_W = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     req_valid,
  input  logic [1:0]               req_mode,
  input  logic                     req_is_branch,
  input  logic [$clog2(NREGS)-1:0] req_rs1,
  input  logic [$clog2(NREGS)-1:0] req_rs2,
  input  logic [IMM_W-1:0]         req_imm,
  input  logic [DISP_W-1:0]        req_disp,
  input  logic [XLEN-1:0]          req_pc,
  input  logic [1:0]               req_size,
  output logic                     out_valid,
  output logic [XLEN-1:0]          out_addr,
  output logic                     out_misalign,
  output logic                     out_mode_fault
);
  localparam int IDX_W = $clog2(NREGS);
  localparam logic [1:0] M_PCREL = 2'd0;
  localparam logic [1:0] M_RIMM  = 2'd1;
  localparam logic [1:0] M_RREG  = 2'd2;

  logic [XLEN-1:0] rf_q [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf_q[i] <= '0;
    end else if (wr_en && wr_idx != '0) begin
      rf_q[wr_idx] <= wr_data;
    end
  end

  logic [XLEN-1:0] src_a, src_b, imm_x, disp_x, sum, mask;
  logic            bad_mode, mis;

  assign src_a  = (req_rs1 == IDX_W'(0)) ? '0 : rf_q[req_rs1];
  assign src_b  = (req_rs2 == IDX_W'(0)) ? '0 : rf_q[req_rs2];
  assign imm_x  = {{(XLEN-IMM_W){req_imm[IMM_W-1]}}, req_imm};
  assign disp_x = {{(XLEN-DISP_W-2){req_disp[DISP_W-1]}}, req_disp, 2'b00};
  assign mask   = (XLEN'(1) << req_size) - XLEN'(1);

  always_comb begin
    sum      = '0;
    bad_mode = 1'b0;
    case (req_mode)
      M_PCREL: begin
        sum      = req_pc + disp_x;
        bad_mode = !req_is_branch;
      end
      M_RIMM:  sum = src_a + imm_x;
      M_RREG:  sum = src_a + src_b;
      default: bad_mode = 1'b1;
    endcase
  end

  assign mis = !req_is_branch && (req_mode == M_RIMM || req_mode == M_RREG) && |(sum & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_addr       <= '0;
      out_misalign   <= 1'b0;
      out_mode_fault <= 1'b0;
    end else begin
      out_valid      <= req_valid;
      out_misalign   <= req_valid && mis;
      out_mode_fault <= req_valid && bad_mode;
      if (req_valid) out_addr <= sum;
    end
  end

  AST_ZERO_REG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '0) |=> (rf_q[0] == '0)); // R7
  AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_misalign && !out_mode_fault)); // R8
  AST_MEM_PCREL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == M_PCREL && !req_is_branch) |=> out_mode_fault); // R4
  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |=> !out_misalign); // R6
  AST_BRANCH_NO_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_branch) |=> !out_misalign); // R10
  AST_LEGAL_NO_MODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_mode == M_RIMM || req_mode == M_RREG)) |=> !out_mode_fault); // R4
endmodule

// File: tb/lsu_addr_gen_bench.sv
module lsu_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        req_is_branch = 1'b0;
  logic [4:0]  req_rs1 = '0, req_rs2 = '0;
  logic [12:0] req_imm = '0;
  logic [29:0] req_disp = '0;
  logic [63:0] req_pc = '0;
  logic [1:0]  req_size = '0;
  logic        out_valid, out_misalign, out_mode_fault;
  logic [63:0] out_addr;

  int n_chk = 0, n_bad = 0;
  logic [63:0] model [32];

  always #10 clk = ~clk;

  lsu_addr_gen u_lsu_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_mode(req_mode), .req_is_branch(req_is_branch),
    .req_rs1(req_rs1), .req_rs2(req_rs2), .req_imm(req_imm), .req_disp(req_disp),
    .req_pc(req_pc), .req_size(req_size), .out_valid(out_valid), .out_addr(out_addr),
    .out_misalign(out_misalign), .out_mode_fault(out_mode_fault));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx != 0) model[idx] = d;
  endtask

  task automatic req(input logic [1:0] m, input logic br, input logic [4:0] a, input logic [4:0] b,
                     input logic [12:0] im, input logic [29:0] dp, input logic [63:0] pc,
                     input logic [1:0] sz);
    logic [63:0] ea, msk;
    logic        emis, emf;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_is_branch = br; req_rs1 = a; req_rs2 = b;
    req_imm = im; req_disp = dp; req_pc = pc; req_size = sz;
    case (m)
      2'd0: ea = pc + ({{34{dp[29]}}, dp} * 64'd4);
      2'd1: ea = model[a] + {{51{im[12]}}, im};
      2'd2: ea = model[a] + model[b];
      default: ea = 64'd0;
    endcase
    msk  = (64'd1 << sz) - 64'd1;
    emis = !br && (m == 2'd1 || m == 2'd2) && ((ea & msk) != 0);
    emf  = (m == 2'd3) || (m == 2'd0 && !br);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 out_valid after request", {63'd0, out_valid}, 64'd1);
    if (m == 2'd0) chk("R1 pc-relative address", out_addr, ea);
    if (m == 2'd1) chk("R2 register+immediate address", out_addr, ea);
    if (m == 2'd2) chk("R3/R7 register+register address", out_addr, ea);
    if (m == 2'd3) chk("R4 reserved mode address", out_addr, ea);
    chk("R4 mode fault", {63'd0, out_mode_fault}, {63'd0, emf});
    if (sz == 2'd0) chk("R6 byte never misaligned", {63'd0, out_misalign}, {63'd0, emis});
    else if (br || m == 2'd0 || m == 2'd3)
      chk("R10 no misalign for branch/pc-rel", {63'd0, out_misalign}, {63'd0, emis});
    else chk("R5 size alignment", {63'd0, out_misalign}, {63'd0, emis});
    @(negedge clk);
    chk("R8 idle outputs quiet", {61'd0, out_valid, out_misalign, out_mode_fault}, 64'd0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] imms [6];
    logic [29:0] disps [6];
    logic [4:0]  ra [6];
    logic [4:0]  rb [3];
    imms  = '{13'd0, 13'd1, 13'h1FFF, 13'd6, 13'h1000, 13'h0FFF};
    disps = '{30'd0, 30'd1, 30'h3FFFFFFF, 30'd5, 30'h20000000, 30'h1FFFFFFF};
    ra    = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd7, 5'd31};
    rb    = '{5'd0, 5'd5, 5'd31};
    for (int i = 0; i < 32; i++) model[i] = 64'd0;
    repeat (3) @(negedge clk);
    chk("R8 reset outputs", {61'd0, out_valid, out_misalign, out_mode_fault}, 64'd0);
    chk("R8 reset address", out_addr, 64'd0);
    rst_n = 1'b1;
    // R9: registers are zero after reset
    req(2'd2, 1'b0, 5'd5, 5'd6, 13'd0, 30'd0, 64'd0, 2'd3);
    // R7: write to register 0 ignored
    wr(5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    req(2'd2, 1'b0, 5'd0, 5'd0, 13'd0, 30'd0, 64'd0, 2'd3);
    req(2'd1, 1'b0, 5'd0, 5'd0, 13'd8, 30'd0, 64'd0, 2'd3);
    for (int i = 1; i < 32; i++)
      wr(5'(i), (i % 2 == 1 ? 64'hF000_0000_0000_0000 : 64'h0000_0001_0000_0000) + 64'(i * 5));
    wr(5'd31, 64'hFFFF_FFFF_FFFF_FFFE);
    // R9: written value visible to next request
    req(2'd2, 1'b0, 5'd2, 5'd0, 13'd0, 30'd0, 64'd0, 2'd0);
    for (int m = 0; m < 4; m++)
      for (int br = 0; br < 2; br++)
        for (int sz = 0; sz < 4; sz++)
          for (int a = 0; a < 6; a++)
            for (int b = 0; b < 3; b++)
              for (int k = 0; k < 6; k++)
                req(2'(m), 1'(br), ra[a], rb[b], imms[k], disps[k],
                    (a % 2 == 0) ? 64'h0000_0000_0000_1000 : 64'hFFFF_FFFF_FFFF_FFF0, 2'(sz));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule